// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target has left stuck. When software raises the recover command and no normal transfer is running, the block looks at the synchronized SDA level. If SDA is held low, it clocks SCL one pulse at a time, up to a parameterized maximum of eight. It samples SDA at the end of each high phase and stops at the first pulse after which SDA reads high. It then generates a STOP condition and raises a sticky done bit. If SDA is already high, for example because SCL is the line that is stuck low, it skips the clock pulses and only issues the STOP sequence.

All phase changes are paced by an external tick strobe. Each SCL phase lasts one tick interval. The outputs are open-drain style drive enables: a 1 pulls the line low. The synchronized SCL and SDA levels are exported as status bits, so software can check after done whether the attempt worked. If SDA is still low when done is raised, the attempt failed.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, both drive enables are 0, the done bit is 0 and no recovery is in progress.
- R2: A recover command presented while `xfer_busy` is 1 is ignored: no SCL or SDA drive follows and done stays 0.
- R3: With SDA low at the command, the block issues SCL pulses (low phase, then a released high phase). It stops pulsing after the first pulse whose high phase ends with SDA high, so a target that lets go after k pulses (1 ≤ k ≤ 8) sees exactly k pulses.
- R4: The block never issues more than MAX_PULSES (8) pulses. If SDA is still low at the end of the last one, done is raised without any SDA drive, and `sda_sts` reads 0.
- R5: The STOP sequence takes four tick phases: SCL driven low, then SDA driven low as well, then SCL released with SDA still low, then SDA released while SCL is not driven. Done is raised only after the final phase.
- R6: With SDA high at the command, no SCL pulse is issued, only the STOP sequence, and done is raised. This also holds when SCL is stuck low, and `scl_sts` then reads 0.
- R7: The done bit stays 1 until `done_clr` is 1 for a cycle, which clears it. A completion in the same cycle as a clear leaves it at 1.
- R8: `scl_sts` and `sda_sts` follow the SCL and SDA inputs through SYNC_STAGES (2) flops. A change becomes visible after the second rising edge, not after the first.
- R9: Once a recovery has started, the sequencer changes phase only in cycles with `tick` at 1. Each released SCL high phase between pulses lasts one full tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_cmd | input | 1 | One-cycle recover command from software |
| xfer_busy | input | 1 | A normal transfer command is executing |
| tick | input | 1 | Phase-pacing strobe, one cycle wide |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| done_clr | input | 1 | Write-one clear of the done bit |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| recover_done | output | 1 | Sticky recovery-complete status |
| scl_sts | output | 1 | Synchronized SCL level |
| sda_sts | output | 1 | Synchronized SDA level |

## Verification
The bench models a target that holds SDA low and lets go after k pulses. k is taken as 0 (SDA already free), 1, 3, 8 (the last allowed pulse) and never. These cases separate an exact pulse count from an off-by-one, a missing or early stop, and the failed-attempt path that must skip the STOP. A case with SCL tied low checks the STOP-only path and the status bit. Further cases cover a command during a busy transfer, the two-stage line status latency and the tick-paced width of the high phase.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_PULSE_LO,
    RS_PULSE_HI,
    RS_STOP_LO,
    RS_STOP_DATA,
    RS_STOP_SETUP,
    RS_STOP_REL
  } rec_state_e;

  // SCL is pulled low in the pulse low phase and the first two STOP phases
  function automatic logic drives_scl(input rec_state_e st);
    return (st == RS_PULSE_LO) || (st == RS_STOP_LO) || (st == RS_STOP_DATA);
  endfunction

  // SDA is pulled low only while the STOP condition is being set up
  function automatic logic drives_sda(input rec_state_e st);
    return (st == RS_STOP_DATA) || (st == RS_STOP_SETUP);
  endfunction

  // another pulse is allowed while fewer than the limit have been issued
  function automatic logic more_pulses(input int unsigned issued, input int unsigned limit);
    return issued < limit;
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= 1'b1;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/done_flag.sv
module done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   done <= 1'b0;
    else if (set) done <= 1'b1;
    else if (clr) done <= 1'b0;

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !done);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(done));
endmodule

// File: rtl/recov_fsm.sv
module recov_fsm
  import i2c_recov_pkg::*;
#(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic tick,
  input  logic sda_ok,
  output logic scl_drv,
  output logic sda_drv,
  output logic finish,
  output logic idle
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  rec_state_e      state, state_nxt;
  logic [CW-1:0]   cnt, cnt_nxt;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    finish    = 1'b0;
    unique case (state)
      RS_IDLE: if (start_req) begin
        if (sda_ok) state_nxt = RS_STOP_LO;
        else begin
          state_nxt = RS_PULSE_LO;
          cnt_nxt   = CW'(1);
        end
      end
      RS_PULSE_LO: if (tick) state_nxt = RS_PULSE_HI;
      RS_PULSE_HI: if (tick) begin
        if (sda_ok) state_nxt = RS_STOP_LO;
        else if (more_pulses(int'(cnt), MAX_PULSES)) begin
          state_nxt = RS_PULSE_LO;
          cnt_nxt   = cnt + CW'(1);
        end else begin
          state_nxt = RS_IDLE;
          finish    = 1'b1;
        end
      end
      RS_STOP_LO:    if (tick) state_nxt = RS_STOP_DATA;
      RS_STOP_DATA:  if (tick) state_nxt = RS_STOP_SETUP;
      RS_STOP_SETUP: if (tick) state_nxt = RS_STOP_REL;
      RS_STOP_REL: if (tick) begin
        state_nxt = RS_IDLE;
        finish    = 1'b1;
      end
      default: state_nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= RS_IDLE;
      cnt     <= '0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
    end else begin
      state   <= state_nxt;
      cnt     <= cnt_nxt;
      scl_drv <= drives_scl(state_nxt);
      sda_drv <= drives_sda(state_nxt);
    end

  assign idle = (state == RS_IDLE);

  // R9
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tick) |=> $stable(state));
  // R4
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_PULSES));
  // R5
  stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drv) |-> !scl_drv);
  // R5
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> !sda_drv);
endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
  parameter int MAX_PULSES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_cmd,
  input  logic xfer_busy,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  input  logic done_clr,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic recover_done,
  output logic scl_sts,
  output logic sda_sts
);
  logic start_req;
  logic finish;
  logic fsm_idle;

  line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_sts));
  line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_sts));

  assign start_req = recover_cmd && !xfer_busy;

  recov_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
    .sda_ok(sda_sts), .scl_drv(scl_drive_low), .sda_drv(sda_drive_low),
    .finish(finish), .idle(fsm_idle));

  done_flag u_done (
    .clk(clk), .rst_n(rst_n), .set(finish), .clr(done_clr),
    .done(recover_done));

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && recover_cmd && xfer_busy) |=> (fsm_idle && !scl_drive_low));
endmodule

// File: tb/i2c_bus_recovery_tb.sv
module i2c_bus_recovery_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_cmd = 1'b0, xfer_busy = 1'b0, done_clr = 1'b0;
  logic tick = 1'b0;
  logic hold = 1'b0, scl_stuck = 1'b0;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_drive_low, recover_done, scl_sts, sda_sts;
  int   checks = 0, fails = 0;
  int   tdiv = 0;
  bit   finished_all = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 7) ? 0 : tdiv + 1;
    tick <= (tdiv == 6);
  end

  assign scl_in = !scl_drive_low && !scl_stuck;
  assign sda_in = !sda_drive_low && !hold;

  i2c_bus_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .recover_cmd(recover_cmd), .xfer_busy(xfer_busy),
    .tick(tick), .scl_in(scl_in), .sda_in(sda_in), .done_clr(done_clr),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .recover_done(recover_done), .scl_sts(scl_sts), .sda_sts(sda_sts));

  // columns: release after k pulses (9 = never), pulses, stops, final sda_sts
  localparam int VEC [0:4][0:3] = '{
    '{1, 1, 1, 1},
    '{3, 3, 1, 1},
    '{8, 8, 1, 1},
    '{9, 8, 0, 0},
    '{0, 0, 1, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_rec(input int k, output int pulses, output int stops,
                         output int gap, output bit got_done);
    bit prev_scl = 1'b0, prev_sda = 1'b0, meas = 1'b0;
    int g = 0;
    pulses = 0; stops = 0; gap = -1; got_done = 1'b0;
    hold = (k > 0);
    repeat (4) @(negedge clk);
    recover_cmd = 1'b1;
    @(negedge clk);
    recover_cmd = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (meas) g++;
      if (scl_drive_low && !prev_scl && meas) begin
        meas = 1'b0;
        gap = g;
      end
      if (!scl_drive_low && prev_scl && !sda_drive_low) begin
        pulses++;
        if (pulses == 1) begin
          meas = 1'b1;
          g = 0;
        end
      end
      if (prev_sda && !sda_drive_low && !scl_drive_low) stops++;
      if (hold && k <= 8 && pulses >= k && !scl_drive_low) hold = 1'b0;
      prev_scl = scl_drive_low;
      prev_sda = sda_drive_low;
      if (recover_done) begin
        got_done = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int p, s, gp;
    bit d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 scl drive", int'(scl_drive_low), 0);
    chk("R1 sda drive", int'(sda_drive_low), 0);
    chk("R1 done", int'(recover_done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: two-flop latency on the status bits
    hold = 1'b1;
    @(negedge clk);
    chk("R8 sda_sts after one edge", int'(sda_sts), 1);
    @(negedge clk);
    chk("R8 sda_sts after two edges", int'(sda_sts), 0);
    hold = 1'b0;
    repeat (3) @(negedge clk);

    // vector table: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 5; v++) begin
      run_rec(VEC[v][0], p, s, gp, d);
      chk($sformatf("R3/R4 pulses k=%0d", VEC[v][0]), p, VEC[v][1]);
      chk($sformatf("R5 stop count k=%0d", VEC[v][0]), s, VEC[v][2]);
      chk($sformatf("R5 done k=%0d", VEC[v][0]), int'(d), 1);
      repeat (3) @(negedge clk);
      chk($sformatf("R4 sda_sts k=%0d", VEC[v][0]), int'(sda_sts), VEC[v][3]);
      if (VEC[v][1] > 0)
        chk($sformatf("R9 high phase width k=%0d", VEC[v][0]), gp, 8);
      repeat (20) @(negedge clk);
      chk("R7 done sticky", int'(recover_done), 1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R7 done cleared", int'(recover_done), 0);
      hold = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R2: command ignored while a transfer runs
    xfer_busy = 1'b1;
    hold = 1'b1;
    repeat (4) @(negedge clk);
    recover_cmd = 1'b1;
    @(negedge clk);
    recover_cmd = 1'b0;
    p = 0;
    for (int i = 0; i < 60; i++) begin
      if (scl_drive_low || sda_drive_low) p++;
      @(negedge clk);
    end
    chk("R2 no drive while busy", p, 0);
    chk("R2 no done while busy", int'(recover_done), 0);
    xfer_busy = 1'b0;
    hold = 1'b0;
    repeat (4) @(negedge clk);

    // R6: SCL stuck low, SDA high -> STOP only
    scl_stuck = 1'b1;
    run_rec(0, p, s, gp, d);
    chk("R6 no pulses with scl stuck", p, 0);
    chk("R6 stop issued", s, 1);
    chk("R6 done", int'(d), 1);
    chk("R6 scl_sts low", int'(scl_sts), 0);
    scl_stuck = 1'b0;

    finished_all = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished_all) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule